// File: doc/BRIEF.md
# Dual-Table Logic Cell with Carry Link

This block is one configurable logic cell of a small reconfigurable fabric. It holds two lookup tables. Each table takes three address bits and drives two independent outputs, so one cell can realise four separate 3-input Boolean functions. The first table takes its address from `lutIn[2:0]` and the second from `lutIn[5:3]`. There is no internal crossbar between the two tables.

The cell is programmed through a serial chain. While `cfgEn` is high, one bit is shifted in on each rising clock edge, and the bit at the far end of the chain appears on `cfgOut` so that cells can be daisy-chained. Once `cfgEn` is low the cell evaluates its functions. Each of the four outputs can be taken straight from its table or from a flip-flop that samples it. A dedicated carry input and carry output join the cell to its horizontal neighbour. With these, the first table supplies propagate and generate terms, and the second table can use the incoming carry to form a sum bit.

Top module: `logic_cell`

## Requirements
- R1: Output k (k = 0..3) is bit `addr` of its own 8-bit truth table. Outputs 0 and 1 belong to table 0, addressed by `lutIn[2:0]`. Outputs 2 and 3 belong to table 1, addressed by `lutIn[5:3]`. The lowest pin of each group is address bit 0.
- R2: The configuration word is 37 bits wide. Bits 8k+7..8k hold the truth table of output k. Bit 32+k selects the registered path for output k (1 = registered). Bit 36 enables carry mode. The word is shifted in bit 0 first, one bit per rising edge while `cfgEn` is high. When the load is complete, the bit shifted first sits in bit 0.
- R3: `cfgOut` shows bit 0 of the chain. While a new word is being shifted in, the i-th edge of the load brings bit i of the previously stored word to `cfgOut`.
- R4: While `cfgEn` is high, `dataOut` and `carryOut` are 0 whatever the other inputs are.
- R5: An output whose select bit is 0 follows its table combinationally, in the same cycle.
- R6: An output whose select bit is 1 shows the table value sampled at the most recent rising edge.
- R7: In carry mode, `carryOut = out1 | (out0 & carryIn)`. Address bit 2 of table 1 comes from `carryIn` instead of `lutIn[5]`.
- R8: With carry mode off, `carryOut` is 0, `carryIn` has no effect on any output, and table 1 uses `lutIn[5]`.
- R9: A synchronous active-high `rst` clears the whole configuration word and all output flip-flops, so every output reads 0.
- R10: The output flip-flops are cleared on every edge while `cfgEn` is high, so registered outputs read 0 right after a load ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfgEn | input | 1 | Configuration mode; shifts the chain |
| cfgIn | input | 1 | Serial configuration data in |
| cfgOut | output | 1 | Serial configuration data out (chain bit 0) |
| lutIn | input | 6 | Table addresses: [2:0] table 0, [5:3] table 1 |
| carryIn | input | 1 | Carry from the neighbouring cell |
| carryOut | output | 1 | Carry to the neighbouring cell |
| dataOut | output | 4 | Cell outputs 0..3 |

## Verification
The carry output and the combinational outputs settle in the cycle their inputs change. The bench therefore drives at a falling edge and checks them one time unit later. A registered output changes only at the next rising edge, so the bench checks it at the following falling edge, with the inputs still held. The bench checks each step of a serial load against the word loaded before, because `cfgOut` moves once per rising edge. It checks the cleared flip-flops in the gap between `cfgEn` falling and the next rising edge.

// File: rtl/cell_pkg.sv
package cell_pkg;
  parameter int LUT_INPUTS     = 3;
  parameter int NUM_TABLES     = 2;
  parameter int OUTS_PER_TABLE = 2;

  localparam int LUT_DEPTH = 1 << LUT_INPUTS;
  localparam int NUM_OUTS  = NUM_TABLES * OUTS_PER_TABLE;
  localparam int IN_W      = NUM_TABLES * LUT_INPUTS;
  localparam int LUT_BITS  = NUM_OUTS * LUT_DEPTH;
  localparam int SEL_BASE  = LUT_BITS;
  localparam int CARRY_BIT = LUT_BITS + NUM_OUTS;
  localparam int CFG_BITS  = CARRY_BIT + 1;

  typedef struct packed {
    logic shiftEn;
    logic clearCfg;
    logic clearRegs;
    logic holdZero;
  } cellStrobes_t;
endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int ADDR_W = 3,
  parameter int OUT_W  = 2
) (
  input  logic [OUT_W*(1<<ADDR_W)-1:0] truth,
  input  logic [ADDR_W-1:0]            addr,
  output logic [OUT_W-1:0]             y
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar o = 0; o < OUT_W; o++) begin : g_out
    logic [DEPTH-1:0] slice;
    assign slice = truth[o*DEPTH +: DEPTH];
    assign y[o]  = slice[addr];
  end
endmodule

// File: rtl/cell_ctrl.sv
module cell_ctrl
  import cell_pkg::*;
(
  input  logic         rst,
  input  logic         cfgEn,
  output cellStrobes_t strb
);
  always_comb begin
    strb.shiftEn   = cfgEn && !rst;
    strb.clearCfg  = rst;
    strb.clearRegs = rst || cfgEn;
    strb.holdZero  = cfgEn;
  end
endmodule

// File: rtl/cell_datapath.sv
module cell_datapath
  import cell_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  cellStrobes_t        strb,
  input  logic                cfgIn,
  output logic                cfgOut,
  input  logic [IN_W-1:0]     lutIn,
  input  logic                carryIn,
  output logic                carryOut,
  output logic [NUM_OUTS-1:0] dataOut
);
  logic [CFG_BITS-1:0] cfgReg;
  logic [NUM_OUTS-1:0] combOut;
  logic [NUM_OUTS-1:0] regOut;
  logic [NUM_OUTS-1:0] selReg;
  logic                carryMode;
  logic                propTerm;
  logic                genTerm;

  // serial configuration chain, bit 0 leaves first
  always_ff @(posedge clk) begin
    if (strb.clearCfg)     cfgReg <= '0;
    else if (strb.shiftEn) cfgReg <= {cfgIn, cfgReg[CFG_BITS-1:1]};
  end

  assign cfgOut    = cfgReg[0];
  assign selReg    = cfgReg[SEL_BASE +: NUM_OUTS];
  assign carryMode = cfgReg[CARRY_BIT];

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_table
    logic [LUT_INPUTS-1:0] addr;
    if (t == NUM_TABLES - 1) begin : g_carry_addr
      always_comb begin
        addr = lutIn[t*LUT_INPUTS +: LUT_INPUTS];
        if (carryMode) addr[LUT_INPUTS-1] = carryIn;
      end
    end else begin : g_plain_addr
      assign addr = lutIn[t*LUT_INPUTS +: LUT_INPUTS];
    end
    lut_table #(.ADDR_W(LUT_INPUTS), .OUT_W(OUTS_PER_TABLE)) u_lut (
      .truth (cfgReg[t*OUTS_PER_TABLE*LUT_DEPTH +: OUTS_PER_TABLE*LUT_DEPTH]),
      .addr  (addr),
      .y     (combOut[t*OUTS_PER_TABLE +: OUTS_PER_TABLE])
    );
  end

  always_ff @(posedge clk) begin
    if (strb.clearRegs) regOut <= '0;
    else                regOut <= combOut;
  end

  for (genvar k = 0; k < NUM_OUTS; k++) begin : g_sel
    assign dataOut[k] = strb.holdZero ? 1'b0 : (selReg[k] ? regOut[k] : combOut[k]);
  end

  assign propTerm = combOut[0];
  assign genTerm  = combOut[1];
  assign carryOut = !strb.holdZero && carryMode && (genTerm || (propTerm && carryIn));

  // R4: outputs held low in configuration mode
  p_hold_zero_r4: assert property (@(posedge clk) disable iff (rst)
    strb.holdZero |-> (dataOut == '0 && !carryOut));

  // R2: the chain only moves while shifting
  p_cfg_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !strb.shiftEn |=> $stable(cfgReg));

  // R3: chain output advances by one stage per shift
  p_chain_step_r3: assert property (@(posedge clk) disable iff (rst)
    strb.shiftEn |=> cfgOut == $past(cfgReg[1]));

  // R10: flip-flops are empty after a clearing edge
  p_regs_clear_r10: assert property (@(posedge clk) disable iff (rst)
    strb.clearRegs |=> regOut == '0);

  // R6: flip-flops capture the table values
  p_regs_follow_r6: assert property (@(posedge clk) disable iff (rst)
    !strb.clearRegs |=> regOut == $past(combOut));

  // R7: a carry needs generate or an incoming carry
  p_carry_source_r7: assert property (@(posedge clk) disable iff (rst)
    carryOut |-> (genTerm || carryIn));

  // R8: no carry out when carry mode is off
  p_carry_off_r8: assert property (@(posedge clk) disable iff (rst)
    !carryMode |-> !carryOut);
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import cell_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgEn,
  input  logic                cfgIn,
  output logic                cfgOut,
  input  logic [IN_W-1:0]     lutIn,
  input  logic                carryIn,
  output logic                carryOut,
  output logic [NUM_OUTS-1:0] dataOut
);
  cellStrobes_t strb;

  cell_ctrl u_ctrl (
    .rst   (rst),
    .cfgEn (cfgEn),
    .strb  (strb)
  );

  cell_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .cfgIn    (cfgIn),
    .cfgOut   (cfgOut),
    .lutIn    (lutIn),
    .carryIn  (carryIn),
    .carryOut (carryOut),
    .dataOut  (dataOut)
  );
endmodule

// File: tb/logic_cell_test.sv
module logic_cell_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfgEn = 1'b0;
  logic       cfgIn = 1'b0;
  logic [5:0] lutIn = '0;
  logic       carryIn = 1'b0;
  logic       cfgOut;
  logic       carryOut;
  logic [3:0] dataOut;

  int tests = 0;
  int fails = 0;
  logic [36:0] prevCfg = '0;

  always #5 clk = ~clk;

  logic_cell uut (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgIn(cfgIn), .cfgOut(cfgOut),
    .lutIn(lutIn), .carryIn(carryIn), .carryOut(carryOut), .dataOut(dataOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected {carryOut, dataOut} from R1, R2, R7, R8
  function automatic logic [4:0] model(input logic [36:0] c, input logic [5:0] li, input logic ci);
    logic [2:0] a0, a1;
    logic o0, o1, o2, o3, co;
    a0 = li[2:0];
    a1 = {c[36] ? ci : li[5], li[4:3]};
    o0 = c[int'(a0)];
    o1 = c[8 + int'(a0)];
    o2 = c[16 + int'(a1)];
    o3 = c[24 + int'(a1)];
    co = c[36] & (o1 | (o0 & ci));
    return {co, o3, o2, o1, o0};
  endfunction

  task automatic loadCfg(input logic [36:0] cfg);
    @(negedge clk);
    cfgEn = 1'b1;
    lutIn = 6'h3F;
    carryIn = 1'b1;
    for (int i = 0; i < 37; i++) begin
      cfgIn = cfg[i];
      #1;
      check("R3 chain out", {7'b0, cfgOut}, {7'b0, prevCfg[i]});
      check("R4 hold zero", {3'b0, carryOut, dataOut}, 8'h00);
      @(negedge clk);
    end
    cfgEn = 1'b0;
    #1;
    for (int k = 0; k < 4; k++)
      if (cfg[32+k]) check("R10 regs cleared", {7'b0, dataOut[k]}, 8'h00);
    prevCfg = cfg;
  endtask

  task automatic sweep(input logic [36:0] cfg);
    logic [4:0] e;
    string tag;
    for (int li = 0; li < 64; li++) begin
      for (int ci = 0; ci < 2; ci++) begin
        @(negedge clk);
        lutIn = li[5:0];
        carryIn = ci[0];
        e = model(cfg, li[5:0], ci[0]);
        #1;
        for (int k = 0; k < 4; k++)
          if (!cfg[32+k]) check("R1 R5 comb output", {7'b0, dataOut[k]}, {7'b0, e[k]});
        tag = cfg[36] ? "R7 carry" : "R8 carry off";
        check(tag, {7'b0, carryOut}, {7'b0, e[4]});
        @(negedge clk);
        #1;
        for (int k = 0; k < 4; k++)
          if (cfg[32+k]) check("R6 registered output", {7'b0, dataOut[k]}, {7'b0, e[k]});
      end
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [36:0] adder, patB, patC, patD;
    adder = {1'b1, 4'b0000, 8'hE8, 8'h96, 8'h88, 8'h66};
    patB  = {1'b0, 4'b0000, 32'hA5C3_961E};
    patC  = {1'b1, 4'b1111, 32'h3C5A_E817};
    patD  = {1'b0, 4'b1010, 32'h0FF0_6B2D};

    repeat (3) @(negedge clk);
    #1;
    check("R9 reset outputs", {3'b0, carryOut, dataOut}, 8'h00);
    check("R9 reset chain", {7'b0, cfgOut}, 8'h00);
    rst = 1'b0;

    loadCfg(adder);
    sweep(adder);
    // explicit adder arithmetic, R7: a=lutIn[0], b=lutIn[1], sum on output 2
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      lutIn = {1'b0, v[1], v[0], 1'b0, v[1], v[0]};
      carryIn = v[2];
      #1;
      check("R7 adder", {6'b0, carryOut, dataOut[2]},
            8'(int'(v[0]) + int'(v[1]) + int'(v[2])));
    end

    loadCfg(patB);
    sweep(patB);
    loadCfg(patC);
    sweep(patC);
    loadCfg(patD);
    sweep(patD);

    // R9: mid-run reset wipes configuration and flip-flops
    @(negedge clk);
    lutIn = 6'h3F;
    carryIn = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int li = 0; li < 64; li += 9) begin
      @(negedge clk);
      lutIn = li[5:0];
      #1;
      check("R9 cleared config", {3'b0, carryOut, dataOut}, 8'h00);
    end
    check("R9 cleared chain", {7'b0, cfgOut}, 8'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule